// File: doc/BRIEF.md
# Booth-Recoded Sequential Signed Multiplier

This block multiplies two WIDTH-bit two's-complement numbers, a multiplicand and a multiplier, and returns their 2·WIDTH-bit signed product. It works through the multiplier a few bits per clock. Each slice of bits is recoded into one signed digit. The digit selects zero, the multiplicand, its negation or (in bit-pair mode) twice either of them. That summand is taken at full product width and added into an accumulator. Long runs of ones in the multiplier then cost only two nonzero digits. A negative multiplier is handled by the recoding itself, so no correction pass follows.

A parameter picks the recoding. Single-bit recoding takes WIDTH steps. Bit-pair recoding takes WIDTH/2 steps and needs an even WIDTH.

The caller pulses `start` with both operands. It then waits for the one-cycle `done` pulse and reads `product`, which stays put until the next accepted start. Any start seen while `busy` is high is discarded.

Top module: `booth_seq_mul`

## Requirements
- R1: `product` equals the signed product of the two operands as a 2·WIDTH-bit two's-complement value, for every operand pair, including the most negative value on either side or both.
- R2: With RADIX4=0, bit i of the multiplier and the bit below it form a digit: 01 gives +M, 10 gives −M, and 00 or 11 give zero. An implied 0 stands below bit 0. `done` rises in the (WIDTH+1)-th cycle after the clock edge that accepts `start`.
- R3: With RADIX4=1, the bits (i+1, i, i−1) for even i form a digit: 000 and 111 give 0, 001 and 010 give +1, 011 gives +2, 100 gives −2, and 101 and 110 give −1. `done` rises in the (WIDTH/2+1)-th cycle after the accepting edge. WIDTH must be even.
- R4: `busy` is high from the edge that accepts `start` up to the edge that raises `done`. `done` is high for exactly one cycle, and never together with `busy`.
- R5: A `start` sampled while `busy` is high is ignored. This holds during the final step as well: the running result, its timing and its operands are unaffected, and no second operation follows.
- R6: A `start` sampled in the cycle where `done` is high is accepted, and a new operation begins on that edge.
- R7: After `done`, `product` holds its value until the next accepted `start`.
- R8: After reset, `busy`, `done` and `product` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication with the current operands (only while idle) |
| mcand | input | WIDTH | Multiplicand, two's complement |
| mplier | input | WIDTH | Multiplier, two's complement |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: product is valid |
| product | output | 2*WIDTH | Signed product |

## Verification
Two events can fall in the same cycle, and each must go a different way. A new `start` can arrive during the last step, while `busy` is still high. A new `start` can also arrive in the cycle where `done` is pulsing. The bench drives `start` with different operands in each of these cycles, and also partway through an operation. It then checks `busy`, `done` and `product` cycle by cycle. The start during the last step must leave no trace: the original product is reported, and nothing follows it. The start in the `done` cycle must launch a second operation at once, with the expected timing and product. Exhaustive operand sweeps in both recoding modes cover the arithmetic.

// File: rtl/booth_mul_pkg.sv
`timescale 1ns/1ps
package booth_mul_pkg;
   typedef enum logic [2:0] {
      DG_ZERO   = 3'd0,
      DG_PLUS1  = 3'd1,
      DG_MINUS1 = 3'd2,
      DG_PLUS2  = 3'd3,
      DG_MINUS2 = 3'd4
   } digit_e;
endpackage

// File: rtl/booth_digit_sel.sv
`timescale 1ns/1ps
// Recodes a window of multiplier bits into one signed digit.
module booth_digit_sel
   import booth_mul_pkg::*;
#(
   parameter bit RADIX4 = 1'b0,
   localparam int WIN = RADIX4 ? 3 : 2
) (
   input  logic [WIN-1:0] win,
   output digit_e         digit
);
   generate
      if (RADIX4) begin : g_pair
         // R3: triple (b[i+1], b[i], b[i-1]) -> digit in -2..+2
         always_comb begin
            case (win)
               3'b001, 3'b010: digit = DG_PLUS1;
               3'b011:         digit = DG_PLUS2;
               3'b100:         digit = DG_MINUS2;
               3'b101, 3'b110: digit = DG_MINUS1;
               default:        digit = DG_ZERO;
            endcase
         end
      end else begin : g_single
         // R2: pair (b[i], b[i-1]) -> digit in -1..+1
         always_comb begin
            case (win)
               2'b01:   digit = DG_PLUS1;
               2'b10:   digit = DG_MINUS1;
               default: digit = DG_ZERO;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/booth_summand.sv
`timescale 1ns/1ps
// Forms the full-width summand for one digit from the sign-extended,
// already shifted multiplicand.
module booth_summand
   import booth_mul_pkg::*;
#(
   parameter int PW = 8
) (
   input  digit_e        digit,
   input  logic [PW-1:0] mc,
   output logic [PW-1:0] addend
);
   logic [PW-1:0] mc_x2;
   assign mc_x2 = {mc[PW-2:0], 1'b0};

   always_comb begin
      case (digit)
         DG_PLUS1:  addend = mc;
         DG_MINUS1: addend = ~mc + PW'(1);
         DG_PLUS2:  addend = mc_x2;
         DG_MINUS2: addend = ~mc_x2 + PW'(1);
         default:   addend = '0;
      endcase
   end
endmodule

// File: rtl/booth_step_ctrl.sv
`timescale 1ns/1ps
// Sequencer: accepts start when idle, counts STEPS steps, pulses done.
module booth_step_ctrl #(
   parameter int STEPS = 8,
   localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic busy,
   output logic done
);
   logic [CW-1:0] count;
   logic          last;

   assign load = start && !busy;
   assign last = (count == CW'(STEPS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         count <= '0;
      end else if (load) begin
         busy  <= 1'b1;
         done  <= 1'b0;
         count <= '0;
      end else if (busy) begin
         count <= count + CW'(1);
         if (last) begin
            busy <= 1'b0;
            done <= 1'b1;
         end else begin
            done <= 1'b0;
         end
      end else begin
         done <= 1'b0;
      end
   end

   // R5: mid-run steps advance regardless of start
   assert_ignore_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last) |=> (busy && count == CW'($past(count) + CW'(1))));

   // R6: a start seen while idle (including the done cycle) opens a run
   assert_accept_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && count == '0));
endmodule

// File: rtl/booth_seq_mul.sv
`timescale 1ns/1ps
// Sequential signed multiplier with single-bit or bit-pair Booth recoding.
module booth_seq_mul
   import booth_mul_pkg::*;
#(
   parameter int WIDTH  = 16,
   parameter bit RADIX4 = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [WIDTH-1:0]   mcand,
   input  logic [WIDTH-1:0]   mplier,
   output logic               busy,
   output logic               done,
   output logic [2*WIDTH-1:0] product
);
   localparam int PW    = 2 * WIDTH;
   localparam int SH    = RADIX4 ? 2 : 1;
   localparam int WIN   = RADIX4 ? 3 : 2;
   localparam int STEPS = RADIX4 ? WIDTH / 2 : WIDTH;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("booth_seq_mul: WIDTH must be at least 2");
      end
      if (RADIX4 && (WIDTH % 2 != 0)) begin : g_bad_pair
         $error("booth_seq_mul: bit-pair recoding needs an even WIDTH");
      end
   endgenerate

   logic          load;
   logic [PW-1:0] acc_q;
   logic [PW-1:0] mc_q;
   logic [WIDTH:0] mq_q;
   logic [PW-1:0] addend;
   digit_e        digit;

   booth_step_ctrl #(.STEPS(STEPS)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .load  (load),
      .busy  (busy),
      .done  (done)
   );

   booth_digit_sel #(.RADIX4(RADIX4)) u_digit (
      .win   (mq_q[WIN-1:0]),
      .digit (digit)
   );

   booth_summand #(.PW(PW)) u_summand (
      .digit  (digit),
      .mc     (mc_q),
      .addend (addend)
   );

   // Multiplicand shifts left and the multiplier shifts right arithmetically,
   // so the low window always holds the next digit's bits.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         mc_q  <= '0;
         mq_q  <= '0;
      end else if (load) begin
         acc_q <= '0;
         mc_q  <= {{WIDTH{mcand[WIDTH-1]}}, mcand};
         mq_q  <= {mplier, 1'b0};
      end else if (busy) begin
         acc_q <= acc_q + addend;
         mc_q  <= mc_q << SH;
         mq_q  <= $signed(mq_q) >>> SH;
      end
   end

   assign product = acc_q;

   // R4: done lasts one cycle and never overlaps busy
   assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R7: result holds while idle and no start arrives
   assert_hold_product_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(product));
endmodule

// File: tb/booth_seq_mul_bench.sv
`timescale 1ns/1ps
module booth_seq_mul_bench;
   localparam int W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic           st2 = 1'b0, st4 = 1'b0;
   logic [W-1:0]   m2 = '0, q2 = '0, m4 = '0, q4 = '0;
   logic           busy2, done2, busy4, done4;
   logic [2*W-1:0] prod2, prod4;

   booth_seq_mul #(.WIDTH(W), .RADIX4(1'b0)) u_booth_seq_mul (
      .clk(clk), .rst_n(rst_n), .start(st2), .mcand(m2), .mplier(q2),
      .busy(busy2), .done(done2), .product(prod2));

   booth_seq_mul #(.WIDTH(W), .RADIX4(1'b1)) u_booth_seq_mul_r4 (
      .clk(clk), .rst_n(rst_n), .start(st4), .mcand(m4), .mplier(q4),
      .busy(busy4), .done(done4), .product(prod4));

   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input string req, input string what, input int act, input int expv);
      n_chk++;
      if (act != expv) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
      int p;
      p = $signed(a) * $signed(b);
      return p[2*W-1:0];
   endfunction

   task automatic drive(input bit r4, input bit s, input logic [W-1:0] a, input logic [W-1:0] b);
      if (r4) begin st4 = s; m4 = a; q4 = b; end
      else    begin st2 = s; m2 = a; q2 = b; end
   endtask

   // One operation; optionally a second start at sample index inj_k (0 = none).
   task automatic run(input bit r4, input logic [W-1:0] a, input logic [W-1:0] b,
                      input int inj_k, input logic [W-1:0] a2, input logic [W-1:0] b2);
      int s_n;
      bit taken;
      int last_k;
      string rq;
      logic [2*W-1:0] e1, e2;
      s_n    = r4 ? W / 2 : W;
      rq     = r4 ? "R3" : "R2";
      taken  = (inj_k > s_n);
      last_k = taken ? inj_k + s_n + 2 : s_n + 3;
      e1 = ref_mul(a, b);
      e2 = ref_mul(a2, b2);
      @(negedge clk); drive(r4, 1'b1, a, b);
      @(negedge clk); drive(r4, 1'b0, a, b);
      for (int k = 1; k <= last_k; k++) begin
         int rel;
         logic [2*W-1:0] ev;
         logic ob, od;
         logic [2*W-1:0] op;
         bit second;
         second = taken && (k > inj_k);
         rel = second ? k - inj_k : k;
         ev  = second ? e2 : e1;
         ob  = r4 ? busy4 : busy2;
         od  = r4 ? done4 : done2;
         op  = r4 ? prod4 : prod2;
         chk(inj_k > 0 ? "R5/R6 busy" : "R4 busy", rq, int'(ob), int'(rel <= s_n));
         chk(inj_k > 0 ? "R5/R6 done" : "R4 done", rq, int'(od), int'(rel == s_n + 1));
         if (rel == s_n + 1)
            chk("R1 product", rq, int'($signed(op)), int'($signed(ev)));
         else if (rel > s_n + 1)
            chk("R7 hold", rq, int'($signed(op)), int'($signed(ev)));
         if (k == inj_k) drive(r4, 1'b1, a2, b2);
         else            drive(r4, 1'b0, a2, b2);
         @(negedge clk);
      end
      drive(r4, 1'b0, '0, '0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R8: reset state
      chk("R8", "busy2", int'(busy2), 0);
      chk("R8", "done2", int'(done2), 0);
      chk("R8", "prod2", int'(prod2), 0);
      chk("R8", "busy4", int'(busy4), 0);
      chk("R8", "prod4", int'(prod4), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R3: exhaustive sweeps in both recodings
      for (int r = 0; r < 2; r++)
         for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
               run(r[0], a[W-1:0], b[W-1:0], 0, '0, '0);

      // Worst-case alternating multiplier and extreme operands
      run(1'b0, 4'b1000, 4'b0101, 0, '0, '0);
      run(1'b1, 4'b1000, 4'b1000, 0, '0, '0);

      // R5: start mid-run and on the last step is ignored
      run(1'b0, 4'd5, 4'b1010, 2, 4'd7, 4'd3);
      run(1'b0, 4'b1101, 4'd6, 4, 4'd7, 4'd7);
      run(1'b1, 4'd3, 4'b1011, 1, 4'd6, 4'd6);
      run(1'b1, 4'b1001, 4'd7, 2, 4'd1, 4'd1);

      // R6: start in the done cycle is accepted back-to-back
      run(1'b0, 4'd6, 4'b1111, 5, 4'b1000, 4'd7);
      run(1'b1, 4'b1110, 4'd5, 3, 4'd7, 4'b1001);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule